// File: doc/BRIEF.md
# Protected Control Register Byte Handler

This block is the byte layer of a serial-bus slave that owns a single nonvolatile control register. A bit-level front end sends it a strobe for each START, a strobe for each STOP and each received byte. For every byte the block answers with an acknowledge decision one clock later. It recognises the register by the device-type preamble in the upper four bits of the slave byte, which must be `1011`. It checks that the 9-bit register address is 1FFh. Address bit 8 travels in bit 1 of the slave byte, and the byte after it carries address bits 7..0.

Changes to the register are guarded by two volatile latches: a write-enable latch and a register-write-enable latch. A full update takes three write transactions. The first sets the write-enable latch. The second, with the write-enable latch already set, sets the register-write-enable latch. The third carries the new settings, which are stored when the STOP arrives. A modelled nonvolatile busy interval follows, and while it runs no slave byte is acknowledged. Each write accepts only one data byte, and nothing takes effect before the STOP.

A random read works as follows. The master sends a write slave byte and the address, then a repeated START and a read slave byte. The block returns the current register image, one byte per transaction.

Register image, bit 7 to bit 0: PUP1, WD1, WD0, BP, constant 0, RWEL, WEL, PUP0. Of these, bits 7..4 and bit 0 are the retained (nonvolatile) settings.

Top module: `ccr_byte_handler`

## Requirements
- R1: A slave byte (the first byte after START) is acknowledged only when bits 7..4 equal 1011 and no busy interval is running. Bit 0 selects the direction (0 = write, 1 = read) and bit 1 is address bit 8. Any other slave byte is not acknowledged, and the rest of that transaction is ignored and leaves the register unchanged.
- R2: After a write slave byte, the address byte is acknowledged only when {slave bit 1, address byte} equals 1FFh. A matching address arms the read pointer. A mismatching address disarms it and makes the rest of the transaction ignored.
- R3: In a write, the first data byte after a matching address is acknowledged. Every further data byte in the same transaction is not acknowledged and is discarded.
- R4: A read slave byte is acknowledged only when the read pointer is armed. When it is acknowledged, the block presents the register image {PUP1,WD1,WD0,BP,0,RWEL,WEL,PUP0} once, with tx_valid_o high in the same cycle as the acknowledge. Later bytes in that read are not acknowledged and produce no further read data.
- R5: At STOP, a pending data byte with bit 1 = 1 and bit 2 = 0 sets WEL, provided RWEL is clear.
- R6: At STOP, a pending data byte with bits 2 and 1 both 1 sets RWEL, provided WEL is already set and RWEL is clear.
- R7: At STOP, with WEL and RWEL both set, a pending data byte with bit 2 = 0 commits its bits 7..4 and bit 0 to the retained settings. The same commit clears WEL and RWEL.
- R8: Any other pending data byte leaves the whole register image unchanged. In particular, no retained bit changes without both latches set.
- R9: A STOP with no pending data byte changes nothing. A repeated START discards a pending data byte without applying it.
- R10: From the clock edge that commits, busy_o is high for BUSY_CYCLES cycles. During that time, slave bytes are not acknowledged.
- R11: After reset, the retained bits equal NV_INIT masked to bits 7..4 and 0, WEL and RWEL are 0, busy_o is 0 and no acknowledge is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START or repeated START strobe from the bit layer |
| stop_i | input | 1 | STOP strobe from the bit layer |
| byte_valid_i | input | 1 | A received byte is on byte_i |
| byte_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | Acknowledge decision valid (one cycle after byte_valid_i) |
| ack_o | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| tx_valid_o | output | 1 | Read data presented for a read transaction |
| tx_data_o | output | 8 | Register image to shift out |
| ctrl_o | output | 8 | Current register image |
| busy_o | output | 1 | Modelled nonvolatile cycle in progress |

## Verification
Faults in the latches or in the retained bits appear in ctrl_o on the clock edge after the STOP that applied them. They also appear in the next read image, so one wrong latch decision is visible within a single transaction. A wrong decoder state shows up as a wrong ack_o on the very next byte. A stale pending byte or a wrongly armed read pointer is exposed by the transaction that follows it. The bench sweeps every slave byte, every 9-bit address and every data value, starting from a latch state predicted by the bench, so each of these faults reaches a port within tens of cycles.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] REG_PREAMBLE = 4'b1011;
  localparam logic [8:0] REG_ADDR = 9'h1FF;
  localparam logic [BYTE_W-1:0] NV_MASK = 8'hF1;
  localparam int B_WEL = 1;
  localparam int B_RWEL = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SLAVE, ST_ADDR, ST_DATA, ST_READ
  } hstate_t;

  typedef enum logic [1:0] {
    ACT_NONE, ACT_SET_WEL, ACT_SET_RWEL, ACT_COMMIT
  } latch_act_t;

  function automatic logic preamble_hit(input logic [BYTE_W-1:0] b);
    return b[7:4] == REG_PREAMBLE;
  endfunction

  function automatic logic addr_hit(input logic a8, input logic [BYTE_W-1:0] b);
    return {a8, b} == REG_ADDR;
  endfunction

  function automatic logic [BYTE_W-1:0] reg_image(input logic [BYTE_W-1:0] nv,
                                                  input logic wel, input logic rwel);
    logic [BYTE_W-1:0] img;
    img = nv & NV_MASK;
    img[B_WEL] = wel;
    img[B_RWEL] = rwel;
    return img;
  endfunction

  function automatic latch_act_t classify(input logic [BYTE_W-1:0] d,
                                          input logic wel, input logic rwel);
    if (wel && rwel && !d[B_RWEL]) return ACT_COMMIT;
    if (d[B_RWEL] && d[B_WEL] && wel && !rwel) return ACT_SET_RWEL;
    if (!d[B_RWEL] && d[B_WEL] && !rwel) return ACT_SET_WEL;
    return ACT_NONE;
  endfunction
endpackage

// File: rtl/ccr_busy_timer.sv
module ccr_busy_timer #(
  parameter int BUSY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load_i) cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  assert_busy_after_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> busy_o);
endmodule

// File: rtl/ccr_latch_ctrl.sv
module ccr_latch_ctrl
  import ccr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] NV_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              wel_o,
  output logic              rwel_o,
  output logic [BYTE_W-1:0] nv_o,
  output logic              commit_o
);
  logic wel, rwel;
  logic [BYTE_W-1:0] nv;
  latch_act_t act;

  always_comb begin
    act = apply_i ? classify(data_i, wel, rwel) : ACT_NONE;
  end

  assign commit_o = (act == ACT_COMMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
      nv   <= NV_INIT & NV_MASK;
    end else begin
      case (act)
        ACT_SET_WEL:  wel <= 1'b1;
        ACT_SET_RWEL: rwel <= 1'b1;
        ACT_COMMIT: begin
          nv   <= data_i & NV_MASK;
          wel  <= 1'b0;
          rwel <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign wel_o  = wel;
  assign rwel_o = rwel;
  assign nv_o   = nv;

  assert_rwel_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);
  assert_commit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (!wel && !rwel));
  assert_nv_only_on_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_o |=> $stable(nv));
endmodule

// File: rtl/ccr_byte_handler.sv
module ccr_byte_handler
  import ccr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] NV_INIT = 8'h00,
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic              busy_o
);
  hstate_t st;
  logic a8_q, ptr_ok, have_data;
  logic [BYTE_W-1:0] data_q;
  logic wel, rwel, commit_ev, apply_ev, busy;
  logic [BYTE_W-1:0] nv;
  logic [BYTE_W-1:0] image;

  assign apply_ev = stop_i && !start_i && have_data;
  assign image = reg_image(nv, wel, rwel);

  ccr_latch_ctrl #(.NV_INIT(NV_INIT)) u_latch (
    .clk(clk), .rst_n(rst_n), .apply_i(apply_ev), .data_i(data_q),
    .wel_o(wel), .rwel_o(rwel), .nv_o(nv), .commit_o(commit_ev)
  );

  ccr_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .load_i(commit_ev), .busy_o(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      a8_q        <= 1'b0;
      ptr_ok      <= 1'b0;
      have_data   <= 1'b0;
      data_q      <= '0;
      ack_valid_o <= 1'b0;
      ack_o       <= 1'b0;
      tx_valid_o  <= 1'b0;
      tx_data_o   <= '0;
    end else begin
      ack_valid_o <= 1'b0;
      tx_valid_o  <= 1'b0;
      if (start_i) begin
        st        <= ST_SLAVE;
        have_data <= 1'b0;
      end else if (stop_i) begin
        st        <= ST_IDLE;
        have_data <= 1'b0;
      end else if (byte_valid_i) begin
        ack_valid_o <= 1'b1;
        ack_o       <= 1'b0;
        case (st)
          ST_SLAVE: begin
            if (!busy && preamble_hit(byte_i)) begin
              if (byte_i[0]) begin
                if (ptr_ok) begin
                  ack_o      <= 1'b1;
                  tx_valid_o <= 1'b1;
                  tx_data_o  <= image;
                  st         <= ST_READ;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                ack_o <= 1'b1;
                a8_q  <= byte_i[1];
                st    <= ST_ADDR;
              end
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_ADDR: begin
            if (addr_hit(a8_q, byte_i)) begin
              ack_o  <= 1'b1;
              ptr_ok <= 1'b1;
              st     <= ST_DATA;
            end else begin
              ptr_ok <= 1'b0;
              st     <= ST_IDLE;
            end
          end
          ST_DATA: begin
            if (!have_data) begin
              ack_o     <= 1'b1;
              data_q    <= byte_i;
              have_data <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ctrl_o = image;
  assign busy_o = busy;

  assert_bad_preamble_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && !start_i && !stop_i && st == ST_SLAVE && !preamble_hit(byte_i))
      |=> (ack_valid_o && !ack_o));
  assert_busy_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && !start_i && !stop_i && st == ST_SLAVE && busy)
      |=> (ack_valid_o && !ack_o));
  assert_extra_data_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && !start_i && !stop_i && st == ST_DATA && have_data)
      |=> (ack_valid_o && !ack_o));
  assert_tx_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> (ack_valid_o && ack_o));
  assert_read_no_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && !start_i) |=> !tx_valid_o);
endmodule

// File: tb/sim_ccr_byte_handler.sv
module sim_ccr_byte_handler;
  localparam logic [7:0] INIT = 8'h50;
  localparam int BUSY = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, byte_valid_i = 0;
  logic [7:0] byte_i = 0;
  logic ack_valid_o, ack_o, tx_valid_o, busy_o;
  logic [7:0] tx_data_o, ctrl_o;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] m_nv;
  logic m_wel, m_rwel;

  ccr_byte_handler #(.NV_INIT(INIT), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .ack_valid_o(ack_valid_o),
    .ack_o(ack_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .ctrl_o(ctrl_o), .busy_o(busy_o)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] m_image();
    return {m_nv[7:4], 1'b0, m_rwel, m_wel, m_nv[0]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
  endtask

  task automatic send(input logic [7:0] b, output bit ack, output bit txv,
                      output logic [7:0] txd);
    @(negedge clk) begin byte_i = b; byte_valid_i = 1; end
    @(negedge clk) byte_valid_i = 0;
    ack = ack_valid_o && ack_o;
    txv = tx_valid_o;
    txd = tx_data_o;
  endtask

  task automatic read_reg(output logic [7:0] v, input string tag);
    bit a, t; logic [7:0] d;
    do_start();
    send(8'hB2, a, t, d); check(a, tag, a, 1);
    send(8'hFF, a, t, d); check(a, tag, a, 1);
    do_start();
    send(8'hB1, a, t, d); check(a && t, tag, {a, t}, 3);
    v = d;
    do_stop();
  endtask

  // Bench model of the latch rules, written from R5..R8
  task automatic model_apply(input logic [7:0] d, output bit commit);
    commit = 0;
    case ({m_wel, m_rwel})
      2'b11: if (d[2] == 1'b0) begin
        m_nv = d & 8'hF1; m_wel = 0; m_rwel = 0; commit = 1;
      end
      2'b10: if (d[2] && d[1]) m_rwel = 1;
      2'b00: if (d[1] && !d[2]) m_wel = 1;
      default: ;
    endcase
  endtask

  task automatic write_reg(input logic [7:0] d, input bit extra);
    bit a, t, c; logic [7:0] x;
    do_start();
    send(8'hB2, a, t, x); check(a, "R1 write slave", a, 1);
    send(8'hFF, a, t, x); check(a, "R2 address", a, 1);
    send(d, a, t, x); check(a, "R3 first data", a, 1);
    if (extra) begin
      send(~d, a, t, x); check(!a, "R3 extra data", a, 0);
    end
    do_stop();
    model_apply(d, c);
    if (c) begin
      check(busy_o, "R10 busy after commit", busy_o, 1);
      do_start();
      send(8'hB2, a, t, x); check(!a, "R10 nack while busy", a, 0);
      do_stop();
      repeat (BUSY) @(negedge clk);
      check(!busy_o, "R10 busy ends", busy_o, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit a, t; logic [7:0] d, v;
    m_nv = INIT & 8'hF1; m_wel = 0; m_rwel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check(ctrl_o == m_image(), "R11 reset image", ctrl_o, m_image());
    check(!busy_o && !ack_valid_o, "R11 reset busy/ack", {busy_o, ack_valid_o}, 0);

    // R1 sweep of every slave byte (read pointer not yet armed)
    for (int s = 0; s < 256; s++) begin
      do_start();
      send(8'(s), a, t, d);
      check(a == (s[7:4] == 4'hB && s[0] == 0), "R1 slave sweep", a,
            (s[7:4] == 4'hB && s[0] == 0));
      check(!t, "R4 no read data unarmed", t, 0);
      do_stop();
    end
    check(ctrl_o == m_image(), "R1 sweep no change", ctrl_o, m_image());

    // R2 sweep of every 9-bit address; ends on 1FFh
    for (int h = 0; h < 2; h++) begin
      for (int ad = 0; ad < 256; ad++) begin
        do_start();
        send(8'hB0 | 8'(h << 1), a, t, d);
        send(8'(ad), a, t, d);
        check(a == (h == 1 && ad == 255), "R2 address sweep", a, (h == 1 && ad == 255));
        do_stop();
      end
    end

    // R4 armed read, single byte
    do_start();
    send(8'hB1, a, t, d);
    check(a && t && d == m_image(), "R4 read image", d, m_image());
    send(8'h00, a, t, d);
    check(!a && !t, "R4 second read byte", {a, t}, 0);
    do_stop();

    // R2 mismatching address disarms pointer
    do_start(); send(8'hB2, a, t, d); send(8'hFE, a, t, d); do_stop();
    do_start(); send(8'hB1, a, t, d);
    check(!a, "R2 pointer disarmed", a, 0);
    do_stop();

    // R5 R6 R7 explicit three-step update
    write_reg(8'h02, 1);
    read_reg(v, "R5 read");
    check(v == m_image() && v[1], "R5 WEL set", v, m_image());
    write_reg(8'h06, 0);
    read_reg(v, "R6 read");
    check(v == m_image() && v[2], "R6 RWEL set", v, m_image());
    write_reg(8'hA1, 0);
    read_reg(v, "R7 read");
    check(v == 8'hA1 && v == m_image(), "R7 commit", v, 8'hA1);

    // R8 no latches: retained bits untouched
    write_reg(8'h50, 0);
    check(ctrl_o == m_image() && ctrl_o[7:4] == 4'hA, "R8 no latch no change", ctrl_o, m_image());

    // R9 STOP without data, and repeated START discarding data
    do_start(); send(8'hB2, a, t, d); send(8'hFF, a, t, d); do_stop();
    check(ctrl_o == m_image(), "R9 stop without data", ctrl_o, m_image());
    do_start(); send(8'hB2, a, t, d); send(8'hFF, a, t, d); send(8'h02, a, t, d);
    do_start(); do_stop();
    check(ctrl_o == m_image() && !ctrl_o[1], "R9 restart discards", ctrl_o, m_image());

    // R5..R8 sweep of every data byte from the evolving latch state
    for (int i = 0; i < 256; i++) begin
      write_reg(8'(i), (i % 16) == 0);
      check(ctrl_o == m_image(), "R8 data sweep image", ctrl_o, m_image());
      if ((i % 8) == 0) begin
        read_reg(v, "R4 sweep read");
        check(v == m_image(), "R4 sweep read value", v, m_image());
      end
    end

    // R7 sweep of retained field values through full sequences
    for (int k = 0; k < 32; k++) begin
      logic [7:0] val;
      val = {4'(k >> 1), 1'b0, 2'b00, 1'(k)};
      if (m_wel && m_rwel) write_reg(8'h04, 0);
      if (!m_wel) write_reg(8'h02, 0);
      if (!m_rwel) write_reg(8'h06, 0);
      write_reg(val, 0);
      check(ctrl_o == val, "R7 field sweep", ctrl_o, val);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule